// File: doc/BRIEF.md
# Channel Configuration Command Controller

This block is the configuration front end of a multi-channel input module. A host writes staging registers over a simple single-port bus: the target channel index and that channel's low-low and high-high alarm values. It then writes a command register whose upper four bits carry an operation code and whose lower twelve bits carry a channel configuration word. The command can reset, store or read back the selected channel's configuration, or choose the mains line frequency. Writing the command register starts processing. After a fixed latency the controller raises a done flag in its status word.

The controller uses a two-phase handshake. The host must write the READY code (0000) before it issues the next command. A command that arrives while done or error is still set is rejected and raises the error flag. Unknown codes also raise the error flag.

A sample path runs alongside the command logic. Each incoming sample carries a channel index and an out-of-range flag. An in-range sample passes through and becomes that channel's last good value. An out-of-range sample is replaced according to the channel's stored policy.

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After reset, status_o, readback_o and line_60hz_o are all 0 and smp_valid_o is 0. Every channel's configuration word, low-low value, high-high value and last good value is 0.
- R2: The bus address selects the register written: 0 is the channel select (low log2(NUM_CH) bits), 1 is the low-low staging value, 2 is the high-high staging value and 3 is the command register. The command code sits in bits 15..12 of the command register: 0000 READY, 0001 reset channel, 0010 read channel, 0011 write channel, 0100 50 Hz, 0101 60 Hz.
- R3: A write command stores command bits 9..6 and 1..0, plus both staged alarm values, into the selected channel. Bits 11..10 and 5..2 are stored as 0.
- R4: For an accepted command, status_o bit 15 (done) becomes 1 at the second rising edge, counting the edge that samples the command write as the first.
- R5: Writing code 0000 clears status bit 15 and status bit 14 (error) with the same latency.
- R6: A non-zero code written while bit 15 or bit 14 is set sets bit 14, leaves bit 15 unchanged and is not executed.
- R7: Codes 0110 through 1111 set bit 14, leave bit 15 at 0 and have no other effect.
- R8: A read command places {4'b0, stored 12-bit word} of the selected channel on readback_o by the time bit 15 rises.
- R9: A reset command sets the selected channel's configuration word to 0 and keeps its alarm and last good values.
- R10: Code 0100 drives line_60hz_o to 0 and code 0101 drives it to 1, with the same latency as done.
- R11: A valid sample with smp_oor_i=0 appears on smp_value_o, with smp_valid_o=1, one clock later. It becomes that channel's last good value.
- R12: For a valid sample with smp_oor_i=1, the output depends on the channel's policy in configuration bits 1..0. Policy 01 outputs the low-low value, 10 the high-high value, and 00 or 11 the last good value. The last good value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe |
| bus_addr_i | input | 2 | Host register address |
| bus_wdata_i | input | 16 | Host write data |
| status_o | output | 16 | Bit 15 done, bit 14 error, others 0 |
| readback_o | output | 16 | Configuration word from the last read command |
| line_60hz_o | output | 1 | 1 when 60 Hz mains is selected, 0 for 50 Hz |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 4 | Sample channel index |
| smp_value_i | input | 16 | Sample value |
| smp_oor_i | input | 1 | Sample is out of range |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_value_o | output | 16 | Passed, substituted or retained sample |

## Verification
The assertions assume that the host holds the channel-select and staging registers steady from the command write until done appears. They also assume that no two command-register writes fall in adjacent cycles, so each write passes through the pending stage on its own. The bench keeps within this: every bus write is followed by an idle cycle, and it waits for the status result before it touches a staging register again. Samples are driven only between command exchanges.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;

   typedef enum logic [3:0] {
      CMD_READY = 4'd0,
      CMD_RESET = 4'd1,
      CMD_READ  = 4'd2,
      CMD_WRITE = 4'd3,
      CMD_F50   = 4'd4,
      CMD_F60   = 4'd5
   } cmd_e;

   typedef enum logic [1:0] {
      ADDR_CHAN = 2'd0,
      ADDR_LOLO = 2'd1,
      ADDR_HIHI = 2'd2,
      ADDR_CMD  = 2'd3
   } addr_e;

   // configuration bits that are kept; all others are reserved zero
   localparam logic [11:0] CFG_KEEP_MASK = 12'h3C3;

   typedef struct packed {
      logic reset_ch;
      logic read_ch;
      logic write_ch;
      logic sel50;
      logic sel60;
   } exec_t;

endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
   import cfgcmd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CMD_W  = 4,
   localparam int ARG_W = DATA_W - CMD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmd_we_i,
   input  logic [DATA_W-1:0] cmd_word_i,
   output exec_t             exec_o,
   output logic              done_o,
   output logic              err_o,
   output logic [ARG_W-1:0]  cmd_arg_o
);

   if (CMD_W != 4) begin : g_bad_cmd_w
      $error("cfgcmd_decode: CMD_W must be 4");
   end

   logic              pend_v;
   logic [DATA_W-1:0] pend_word;
   logic [CMD_W-1:0]  code;
   logic              busy, known, accept;

   assign code      = pend_word[DATA_W-1 -: CMD_W];
   assign cmd_arg_o = pend_word[ARG_W-1:0];
   assign busy      = done_o | err_o;
   assign known     = (code <= CMD_F60);
   assign accept    = pend_v && (code != CMD_READY) && !busy && known;

   assign exec_o.reset_ch = accept && (code == CMD_RESET);
   assign exec_o.read_ch  = accept && (code == CMD_READ);
   assign exec_o.write_ch = accept && (code == CMD_WRITE);
   assign exec_o.sel50    = accept && (code == CMD_F50);
   assign exec_o.sel60    = accept && (code == CMD_F60);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_v    <= 1'b0;
         pend_word <= '0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         pend_v <= cmd_we_i;
         if (cmd_we_i) pend_word <= cmd_word_i;
         if (pend_v) begin
            if (code == CMD_READY) begin
               done_o <= 1'b0;
               err_o  <= 1'b0;
            end else if (busy || !known) begin
               err_o <= 1'b1;
            end else begin
               done_o <= 1'b1;
            end
         end
      end
   end

   // R4
   done_two_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(cmd_we_i, 2));

   // R6
   busy_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_v && code != CMD_READY && busy) |=> (err_o && $stable(done_o)));

   // R5
   ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_v && code == CMD_READY) |=> (!done_o && !err_o));

endmodule

// File: rtl/cfgcmd_store.sv
module cfgcmd_store
   import cfgcmd_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int DATA_W = 16,
   parameter int CFG_W  = 12,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CH_W-1:0]   sel_i,
   input  logic              do_reset_i,
   input  logic              do_write_i,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic [DATA_W-1:0] lolo_i,
   input  logic [DATA_W-1:0] hihi_i,
   output logic [CFG_W-1:0]  cfg_o,
   input  logic [CH_W-1:0]   smp_ch_i,
   output logic [1:0]        smp_policy_o,
   output logic [DATA_W-1:0] smp_lolo_o,
   output logic [DATA_W-1:0] smp_hihi_o
);

   if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_num_ch
      $error("cfgcmd_store: NUM_CH must be a power of two, at least 2");
   end
   if (CFG_W < 12) begin : g_bad_cfg_w
      $error("cfgcmd_store: CFG_W must be at least 12");
   end

   localparam logic [CFG_W-1:0] KEEP = CFG_W'(CFG_KEEP_MASK);

   logic [CFG_W-1:0]  cfg_arr  [NUM_CH];
   logic [DATA_W-1:0] lolo_arr [NUM_CH];
   logic [DATA_W-1:0] hihi_arr [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CFG_W-1:0]  cfg_q;
      logic [DATA_W-1:0] lolo_q, hihi_q;
      logic              hit;

      assign hit = (sel_i == CH_W'(c));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cfg_q  <= '0;
            lolo_q <= '0;
            hihi_q <= '0;
         end else if (hit && do_reset_i) begin
            cfg_q <= '0;
         end else if (hit && do_write_i) begin
            cfg_q  <= cfg_i & KEEP;
            lolo_q <= lolo_i;
            hihi_q <= hihi_i;
         end
      end

      assign cfg_arr[c]  = cfg_q;
      assign lolo_arr[c] = lolo_q;
      assign hihi_arr[c] = hihi_q;
   end

   assign cfg_o        = cfg_arr[sel_i];
   assign smp_policy_o = cfg_arr[smp_ch_i][1:0];
   assign smp_lolo_o   = lolo_arr[smp_ch_i];
   assign smp_hihi_o   = hihi_arr[smp_ch_i];

endmodule

// File: rtl/cfgcmd_sample.sv
module cfgcmd_sample #(
   parameter int NUM_CH  = 16,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [CH_W-1:0]   ch_i,
   input  logic [DATA_W-1:0] value_i,
   input  logic              oor_i,
   input  logic [1:0]        policy_i,
   input  logic [DATA_W-1:0] lolo_i,
   input  logic [DATA_W-1:0] hihi_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] value_o
);

   logic [DATA_W-1:0] good_arr [NUM_CH];
   logic [DATA_W-1:0] pick;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_good
      logic [DATA_W-1:0] good_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            good_q <= '0;
         else if (valid_i && !oor_i && ch_i == CH_W'(c))
            good_q <= value_i;
      end
      assign good_arr[c] = good_q;
   end

   always_comb begin
      if (!oor_i)                pick = value_i;
      else if (policy_i == 2'b01) pick = lolo_i;
      else if (policy_i == 2'b10) pick = hihi_i;
      else                       pick = good_arr[ch_i];
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            valid_o <= 1'b0;
            value_o <= '0;
         end else begin
            valid_o <= valid_i;
            if (valid_i) value_o <= pick;
         end
      end

      // R11
      pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (valid_i && !oor_i) |=> (valid_o && value_o == $past(value_i)));
   end else begin : g_comb
      assign valid_o = valid_i;
      assign value_o = pick;
   end

endmodule

// File: rtl/cfgcmd_ctrl.sv
module cfgcmd_ctrl
   import cfgcmd_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int CH_W   = $clog2(NUM_CH),
   localparam int CMD_W  = 4,
   localparam int CFG_W  = DATA_W - CMD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] readback_o,
   output logic              line_60hz_o,
   input  logic              smp_valid_i,
   input  logic [CH_W-1:0]   smp_chan_i,
   input  logic [DATA_W-1:0] smp_value_i,
   input  logic              smp_oor_i,
   output logic              smp_valid_o,
   output logic [DATA_W-1:0] smp_value_o
);

   if (DATA_W < 16) begin : g_bad_data_w
      $error("cfgcmd_ctrl: DATA_W must be at least 16");
   end

   logic [CH_W-1:0]   chan_sel_q;
   logic [DATA_W-1:0] lolo_stage_q, hihi_stage_q;
   logic [DATA_W-1:0] readback_q;
   logic              line60_q;
   exec_t             exec;
   logic              done, err;
   logic [CFG_W-1:0]  cmd_arg, sel_cfg;
   logic [1:0]        smp_policy;
   logic [DATA_W-1:0] smp_lolo, smp_hihi;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chan_sel_q   <= '0;
         lolo_stage_q <= '0;
         hihi_stage_q <= '0;
      end else if (bus_we_i) begin
         case (bus_addr_i)
            ADDR_CHAN: chan_sel_q   <= bus_wdata_i[CH_W-1:0];
            ADDR_LOLO: lolo_stage_q <= bus_wdata_i;
            ADDR_HIHI: hihi_stage_q <= bus_wdata_i;
            default:   ;
         endcase
      end
   end

   cfgcmd_decode #(.DATA_W(DATA_W), .CMD_W(CMD_W)) decode_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_we_i   (bus_we_i && bus_addr_i == ADDR_CMD),
      .cmd_word_i (bus_wdata_i),
      .exec_o     (exec),
      .done_o     (done),
      .err_o      (err),
      .cmd_arg_o  (cmd_arg)
   );

   cfgcmd_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CFG_W(CFG_W)) store_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (chan_sel_q),
      .do_reset_i   (exec.reset_ch),
      .do_write_i   (exec.write_ch),
      .cfg_i        (cmd_arg),
      .lolo_i       (lolo_stage_q),
      .hihi_i       (hihi_stage_q),
      .cfg_o        (sel_cfg),
      .smp_ch_i     (smp_chan_i),
      .smp_policy_o (smp_policy),
      .smp_lolo_o   (smp_lolo),
      .smp_hihi_o   (smp_hihi)
   );

   cfgcmd_sample #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .OUT_REG(OUT_REG)) sample_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (smp_valid_i),
      .ch_i     (smp_chan_i),
      .value_i  (smp_value_i),
      .oor_i    (smp_oor_i),
      .policy_i (smp_policy),
      .lolo_i   (smp_lolo),
      .hihi_i   (smp_hihi),
      .valid_o  (smp_valid_o),
      .value_o  (smp_value_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         readback_q <= '0;
         line60_q   <= 1'b0;
      end else begin
         if (exec.read_ch) readback_q <= DATA_W'(sel_cfg);
         if (exec.sel60)      line60_q <= 1'b1;
         else if (exec.sel50) line60_q <= 1'b0;
      end
   end

   assign status_o    = {done, err, {(DATA_W-2){1'b0}}};
   assign readback_o  = readback_q;
   assign line_60hz_o = line60_q;

   // R10
   line_sel60_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec.sel60 |=> (line_60hz_o && done));

   // R10
   line_sel50_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec.sel50 |=> (!line_60hz_o && done));

endmodule

// File: tb/cfgcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfgcmd_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] status, readback;
   logic        line60;
   logic        smp_vi = 1'b0;
   logic [3:0]  smp_ch = '0;
   logic [15:0] smp_val = '0;
   logic        smp_oor = 1'b0;
   logic        smp_vo;
   logic [15:0] smp_out;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   logic [11:0] m_cfg  [16];
   logic [15:0] m_lolo [16];
   logic [15:0] m_hihi [16];
   logic [15:0] m_good [16];

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   cfgcmd_ctrl dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_we_i    (bus_we),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .status_o    (status),
      .readback_o  (readback),
      .line_60hz_o (line60),
      .smp_valid_i (smp_vi),
      .smp_chan_i  (smp_ch),
      .smp_value_i (smp_val),
      .smp_oor_i   (smp_oor),
      .smp_valid_o (smp_vo),
      .smp_value_o (smp_out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   // issue a command and land on the cycle its result is visible
   task automatic cmd(input logic [15:0] w);
      bus_wr(2'd3, w);
      @(negedge clk);
   endtask

   task automatic clear_ready(input string req);
      cmd(16'h0000);
      chk(req, status, 16'h0000);
   endtask

   task automatic cfg_chan(input int ch, input logic [15:0] lo, input logic [15:0] hi,
                           input logic [11:0] cfg);
      bus_wr(2'd0, 16'(ch));
      bus_wr(2'd1, lo);
      bus_wr(2'd2, hi);
      cmd({4'b0011, cfg});
      chk("R3 write done", status, 16'h8000);
      m_cfg[ch]  = cfg & 12'h3C3;
      m_lolo[ch] = lo;
      m_hihi[ch] = hi;
      clear_ready("R5 clear after write");
   endtask

   // scoreboard driver: drive one sample, push its expected output
   task automatic send(input int ch, input logic [15:0] v, input bit oor);
      logic [15:0] e;
      @(negedge clk);
      smp_vi = 1'b1; smp_ch = 4'(ch); smp_val = v; smp_oor = oor;
      if (!oor) begin
         e = v; m_good[ch] = v;
         tag_q.push_back("R11 pass");
      end else begin
         case (m_cfg[ch][1:0])
            2'b01:   e = m_lolo[ch];
            2'b10:   e = m_hihi[ch];
            default: e = m_good[ch];
         endcase
         tag_q.push_back("R12 substitute");
      end
      exp_q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      smp_vi = 1'b0; smp_oor = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && smp_vo) begin
         if (exp_q.size() == 0) begin
            chk("R11 unexpected output", smp_out, 16'hxxxx);
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, smp_out, e);
         end
      end
   end

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog R4 actual=timeout expected=finish");
      report();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_cfg[i] = '0; m_lolo[i] = '0; m_hihi[i] = '0; m_good[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status, 16'h0000);
      chk("R1 readback", readback, 16'h0000);
      chk("R1 line", {15'b0, line60}, 16'h0000);
      chk("R1 smp valid", {15'b0, smp_vo}, 16'h0000);

      // R2 staging then command; R4 latency
      bus_wr(2'd0, 16'h0003);
      bus_wr(2'd1, 16'h0100);
      bus_wr(2'd2, 16'h7F00);
      bus_wr(2'd3, 16'h3FFD);
      chk("R4 not yet done", status, 16'h0000);
      @(negedge clk);
      chk("R4 done", status, 16'h8000);
      m_cfg[3] = 12'h3C1; m_lolo[3] = 16'h0100; m_hihi[3] = 16'h7F00;
      clear_ready("R5 clear");

      // R8 / R3 readback with reserved bits zero
      cmd(16'h2000);
      chk("R8 read done", status, 16'h8000);
      chk("R3 R8 readback", readback, 16'h03C1);

      // R6 command while done still set
      cmd(16'h3002);
      chk("R6 reject", status, 16'hC000);
      clear_ready("R5 clear both");
      cmd(16'h2000);
      chk("R6 not executed", readback, 16'h03C1);
      clear_ready("R5 clear");

      // R7 unused code
      cmd(16'h7000);
      chk("R7 unused", status, 16'h4000);
      clear_ready("R5 clear err");
      cmd(16'hF123);
      chk("R7 unused high", status, 16'h4000);
      clear_ready("R5 clear err");
      cmd(16'h2000);
      chk("R7 no effect", readback, 16'h03C1);
      clear_ready("R5 clear");

      // R10 line frequency
      cmd(16'h5000);
      chk("R10 60Hz", {status[15:1], line60}, 16'h8001);
      clear_ready("R5 clear");
      cmd(16'h4000);
      chk("R10 50Hz", {status[15:1], line60}, 16'h8000);
      clear_ready("R5 clear");

      // R1 untouched channel reads zero
      bus_wr(2'd0, 16'h0000);
      cmd(16'h2000);
      chk("R1 ch0 config", readback, 16'h0000);
      clear_ready("R5 clear");

      cfg_chan(5, 16'h0011, 16'h1234, 12'h002);
      cfg_chan(6, 16'h0022, 16'h2222, 12'h003);
      cfg_chan(7, 16'h0033, 16'h4444, 12'h040);

      // R11 / R12 sample path
      send(3, 16'h1111, 1'b0);
      send(3, 16'hAAAA, 1'b1);
      send(5, 16'h5555, 1'b0);
      send(5, 16'hBBBB, 1'b1);
      send(6, 16'h6666, 1'b0);
      send(6, 16'hCCCC, 1'b1);
      send(7, 16'h7777, 1'b0);
      send(7, 16'hDDDD, 1'b1);
      send(7, 16'hEEEE, 1'b1);
      send(0, 16'h9999, 1'b1);
      idle();
      repeat (2) @(negedge clk);

      // R9 reset channel 3 config, alarms and last good kept
      bus_wr(2'd0, 16'h0003);
      cmd(16'h1000);
      chk("R9 reset done", status, 16'h8000);
      m_cfg[3] = '0;
      clear_ready("R5 clear");
      cmd(16'h2000);
      chk("R9 config zero", readback, 16'h0000);
      clear_ready("R5 clear");
      send(3, 16'h2222, 1'b1);
      idle();
      repeat (3) @(negedge clk);
      chk("R11 scoreboard drained", 16'(exp_q.size()), 16'h0000);
      report();
   end

endmodule